// File: doc/BRIEF.md
# Reset Cause Capture Register

This block remembers why the system was last reset. It watches four sources: the power-on reset, a one-cycle watchdog overflow pulse, an active-low external reset pin and a one-cycle software reset request. Whenever any of them fires, it drives a system reset output for a fixed number of core clock cycles. It also sets a sticky flag for each source that fired.

Software reads the flags through one 8-bit register on a simple strobe bus. The cause flags keep their value through every reset except power-on, and a read of the register clears them. The same byte holds write-only controls for an external watchdog counter: an enable that can be switched on but not off, and a two-bit interval select. Only the power-on reset clears the flag storage. The control fields are cleared by any reset.

Top module: `rst_cause_reg`

## Requirements
- R1: A read strobe with `bus_addr` equal to 0x0000A8 returns, in the same cycle, bit 7 power-on flag, bit 6 constant 1, bit 5 watchdog flag, bit 4 external-pin flag, bit 3 software flag, and bits 2:0 constant 1. With no read strobe, or with any other address, `bus_rdata` is 0.
- R2: `sys_rst` is high while `por_n` is low and for exactly 16 cycles after `por_n` is released. After power-on the power-on flag (bit 7) reads 1, and the other cause flags are not defined while it is 1.
- R3: A watchdog overflow pulse sets the watchdog flag (bit 5) at the clock edge that samples it.
- R4: The external pin `ext_rst_n` (active low) passes through a two-flop synchroniser. A low level on the pin sets the external flag (bit 4) and starts `sys_rst` at the third clock edge that samples the low level, and not earlier.
- R5: A software reset pulse sets the software flag (bit 3) at the clock edge that samples it.
- R6: Causes that arrive at the same clock edge each set their own flag, in every combination.
- R7: Cause flags are sticky. A later reset from another source leaves earlier flags at 1, and only a matching read clears them.
- R8: A matching read returns the flags as they were before the clear, and all flags are 0 after that clock edge. A cause at the same edge as the clearing read stays set.
- R9: Every cause drives `sys_rst` high from the edge that samples it for exactly 16 cycles, and a new cause reloads the count.
- R10: A write to 0x0000A8 with bit 2 equal to 0 sets `wd_enable`. A write with bit 2 equal to 1 does not clear it. Only a reset (power-on, a cause, or `sys_rst` high) clears it.
- R11: Every write to 0x0000A8 latches bits 1:0 into `wd_interval`. The field is 0 after any reset.
- R12: Writes never change the cause flags or bit 6. Writes to any other address do not change `wd_enable` or `wd_interval`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdog_ovf | input | 1 | Watchdog overflow, one-cycle pulse |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_req | input | 1 | Software reset request, one-cycle pulse |
| bus_addr | input | 24 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sys_rst | output | 1 | Stretched system reset, active high |
| wd_enable | output | 1 | Watchdog enable |
| wd_interval | output | 2 | Watchdog interval select |

## Verification
The watchdog and software pulses take effect at the edge that samples them, so `sys_rst` and the flags change one edge after the pulse is driven. An external pin level takes effect three edges after it is driven. `sys_rst` then stays high for 16 edges. Read data is combinational, so the bench samples it 1 ns after raising the strobe, before the edge that clears the flags. The bench drives every input on the falling edge and samples there, after the rising edge that updates state. The sweep over all eight cause combinations drives the pin two edges before the pulses, so that all three causes reach the capture flops at the same edge.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned BIT_POR   = 7;
   localparam int unsigned BIT_RSVD  = 6;
   localparam int unsigned BIT_WDOG  = 5;
   localparam int unsigned BIT_EXT   = 4;
   localparam int unsigned BIT_SW    = 3;
   localparam int unsigned BIT_WDEN  = 2;
   localparam int unsigned NUM_CAUSE = 3;

   // index of each non-power-on cause inside the cause vector
   localparam int unsigned C_SW   = 0;
   localparam int unsigned C_EXT  = 1;
   localparam int unsigned C_WDOG = 2;

   typedef struct packed {
      logic                 por;
      logic [NUM_CAUSE-1:0] cause;
   } cause_flags_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rcc_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("rcc_stretch needs a positive cycle count");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= LOAD;
      else if (trig)         cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   a_r9_trig_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active);
   a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !trig) |=> (cnt_q == $past(cnt_q) - 1'b1));
   a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !trig) |=> !active);
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags
   import rcc_pkg::*;
(
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 rd_clr,
   input  logic [NUM_CAUSE-1:0] cause_ev,
   output cause_flags_t         flags
);
   logic                 por_q;
   logic [NUM_CAUSE-1:0] cause_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      por_q <= 1'b1;
      else if (rd_clr) por_q <= 1'b0;
   end

   for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) cause_q[i] <= 1'b0;
         else        cause_q[i] <= (cause_q[i] & ~rd_clr) | cause_ev[i];
      end

      a_r7_sticky: assert property (@(posedge clk) disable iff (!por_n)
         (cause_q[i] && !rd_clr) |=> cause_q[i]);
      a_r8_cause_wins: assert property (@(posedge clk) disable iff (!por_n)
         cause_ev[i] |=> cause_q[i]);
   end

   assign flags.por   = por_q;
   assign flags.cause = cause_q;

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!por_n)
      (rd_clr && cause_ev == '0) |=> (!por_q && cause_q == '0));
   a_r2_por_only_falls: assert property (@(posedge clk) disable iff (!por_n)
      !por_q |=> !por_q);
endmodule

// File: rtl/rcc_wdctl.sv
module rcc_wdctl #(
   parameter int unsigned IVL_W = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             clr,
   input  logic             wr_hit,
   input  logic             en_bit,
   input  logic [IVL_W-1:0] ivl_in,
   output logic             wd_en,
   output logic [IVL_W-1:0] ivl
);
   if (IVL_W < 1) begin : g_bad_ivl
      $error("rcc_wdctl needs a non-empty interval field");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wd_en <= 1'b0;
         ivl   <= '0;
      end else if (clr) begin
         wd_en <= 1'b0;
         ivl   <= '0;
      end else if (wr_hit) begin
         if (!en_bit) wd_en <= 1'b1;
         ivl <= ivl_in;
      end
   end

   a_r10_enable_holds: assert property (@(posedge clk) disable iff (!por_n)
      (wd_en && !clr) |=> wd_en);
   a_r11_interval_stable: assert property (@(posedge clk) disable iff (!por_n)
      (!wr_hit && !clr) |=> $stable(ivl));
   a_r10_reset_clears: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (!wd_en && ivl == '0));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rcc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter logic [23:0] REG_ADDR    = 24'h0000A8,
   parameter int unsigned RST_CYCLES  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IVL_W       = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wdog_ovf,
   input  logic              ext_rst_n,
   input  logic              sw_rst_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              sys_rst,
   output logic              wd_enable,
   output logic [IVL_W-1:0]  wd_interval
);
   localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(REG_ADDR);
   localparam logic [IVL_W-1:0]  WO_FILL   = '1;

   if (IVL_W != BIT_WDEN) begin : g_bad_layout
      $error("interval field must fill the bits below the enable bit");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("address bus too narrow for the register address");
   end

   logic                 ext_sync;
   logic [NUM_CAUSE-1:0] cause_ev;
   logic                 cause_any;
   logic                 rd_hit;
   logic                 wr_hit;
   cause_flags_t         flags;

   rcc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (ext_rst_n),
      .q     (ext_sync)
   );

   always_comb begin
      cause_ev         = '0;
      cause_ev[C_WDOG] = wdog_ovf;
      cause_ev[C_EXT]  = ~ext_sync;
      cause_ev[C_SW]   = sw_rst_req;
   end
   assign cause_any = |cause_ev;

   rcc_stretch #(.CYCLES(RST_CYCLES)) u_stretch (
      .clk    (clk),
      .rst_n  (por_n),
      .trig   (cause_any),
      .active (sys_rst)
   );

   assign rd_hit = bus_rd && (bus_addr == MY_ADDR);
   assign wr_hit = bus_wr && (bus_addr == MY_ADDR);

   rcc_flags u_flags (
      .clk      (clk),
      .por_n    (por_n),
      .rd_clr   (rd_hit),
      .cause_ev (cause_ev),
      .flags    (flags)
   );

   rcc_wdctl #(.IVL_W(IVL_W)) u_wdctl (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (cause_any | sys_rst),
      .wr_hit (wr_hit),
      .en_bit (bus_wdata[BIT_WDEN]),
      .ivl_in (bus_wdata[IVL_W-1:0]),
      .wd_en  (wd_enable),
      .ivl    (wd_interval)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         bus_rdata[BIT_POR]     = flags.por;
         bus_rdata[BIT_RSVD]    = 1'b1;
         bus_rdata[BIT_WDOG]    = flags.cause[C_WDOG];
         bus_rdata[BIT_EXT]     = flags.cause[C_EXT];
         bus_rdata[BIT_SW]      = flags.cause[C_SW];
         bus_rdata[BIT_WDEN]    = 1'b1;
         bus_rdata[IVL_W-1:0]   = WO_FILL;
      end
   end

   a_r1_reserved_one: assert property (@(posedge clk) disable iff (!por_n)
      rd_hit |-> (bus_rdata[BIT_RSVD] && bus_rdata[BIT_WDEN]));
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!por_n)
      !rd_hit |-> (bus_rdata == '0));
   a_r12_write_keeps_flags: assert property (@(posedge clk) disable iff (!por_n)
      (wr_hit && !rd_hit && !cause_any) |=> $stable(flags));
endmodule

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
   localparam logic [23:0] RA = 24'h0000A8;
   localparam logic [7:0]  BASE = 8'h47;  // bit 6 and bits 2:0 read as 1

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wdog_ovf = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        sw_rst_req = 1'b0;
   logic [23:0] bus_addr = RA;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        sys_rst;
   logic        wd_enable;
   logic [1:0]  wd_interval;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rst_cause_reg u0 (
      .clk(clk), .por_n(por_n), .wdog_ovf(wdog_ovf), .ext_rst_n(ext_rst_n),
      .sw_rst_req(sw_rst_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst(sys_rst), .wd_enable(wd_enable), .wd_interval(wd_interval)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(logic [23:0] a, output logic [7:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = RA;
   endtask

   task automatic do_write(logic [23:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = RA;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      step(3);
      check("R2 sys_rst during power-on", sys_rst, 1);
      check("R1 idle rdata", bus_rdata, 0);
      por_n = 1'b1;
      step(15);
      check("R2 sys_rst 15 cycles after release", sys_rst, 1);
      step(1);
      check("R2 sys_rst low after 16 cycles", sys_rst, 0);
      check("R10 wd_enable after reset", wd_enable, 0);
      check("R11 wd_interval after reset", wd_interval, 0);
      do_read(RA, v);
      check("R2 power-on flag", v[7], 1);
      do_read(RA, v);
      check("R8 flags cleared by read", v, BASE);
      do_read(24'h0000A9, v);
      check("R1 other address reads 0", v, 0);

      // watchdog pulse and stretch length
      wdog_ovf = 1'b1; step(1); wdog_ovf = 1'b0;
      check("R9 sys_rst after wdog", sys_rst, 1);
      step(15);
      check("R9 sys_rst held 16 cycles", sys_rst, 1);
      step(1);
      check("R9 sys_rst released", sys_rst, 0);
      do_read(RA, v);
      check("R3 watchdog flag", v, BASE | 8'h20);

      // retrigger reloads the count
      sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
      step(10);
      sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
      step(15);
      check("R9 retrigger reloads", sys_rst, 1);
      step(1);
      check("R9 retrigger ends", sys_rst, 0);
      do_read(RA, v);
      check("R5 software flag", v, BASE | 8'h08);

      // external pin latency through the synchroniser
      ext_rst_n = 1'b0; step(1); ext_rst_n = 1'b1;
      step(1);
      check("R4 no reset before third edge", sys_rst, 0);
      step(1);
      check("R4 reset at third edge", sys_rst, 1);
      step(20);
      do_read(RA, v);
      check("R4 external flag", v, BASE | 8'h10);

      // sticky across different causes
      wdog_ovf = 1'b1; step(1); wdog_ovf = 1'b0;
      step(20);
      sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
      step(20);
      do_read(RA, v);
      check("R7 older flag kept", v, BASE | 8'h28);
      do_read(RA, v);
      check("R7 read clears all", v, BASE);

      // all combinations at one edge
      for (int m = 0; m < 8; m++) begin
         logic [7:0] exp;
         exp = BASE | (m[2] ? 8'h20 : 8'h0) | (m[1] ? 8'h10 : 8'h0)
                    | (m[0] ? 8'h08 : 8'h0);
         ext_rst_n = !m[1];
         step(2);
         wdog_ovf = m[2]; sw_rst_req = m[0];
         step(1);
         wdog_ovf = 1'b0; sw_rst_req = 1'b0; ext_rst_n = 1'b1;
         check($sformatf("R6 sys_rst combo %0d", m), sys_rst, (m != 0));
         step(25);
         do_read(RA, v);
         check($sformatf("R6 flags combo %0d", m), v, exp);
      end

      // cause in the same cycle as the clearing read
      sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
      step(20);
      bus_addr = RA; bus_rd = 1'b1; wdog_ovf = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; wdog_ovf = 1'b0;
      check("R8 read returns pre-clear value", v, BASE | 8'h08);
      step(20);
      do_read(RA, v);
      check("R8 same-cycle cause wins", v, BASE | 8'h20);

      // watchdog control fields
      do_write(RA, 8'h05);
      check("R10 bit2=1 leaves enable off", wd_enable, 0);
      check("R11 interval latched 1", wd_interval, 1);
      do_write(RA, 8'h02);
      check("R10 bit2=0 sets enable", wd_enable, 1);
      check("R11 interval latched 2", wd_interval, 2);
      do_write(RA, 8'h07);
      check("R10 bit2=1 does not clear", wd_enable, 1);
      check("R11 interval latched 3", wd_interval, 3);
      do_write(24'h0000A0, 8'h00);
      check("R12 other address keeps enable", wd_enable, 1);
      check("R12 other address keeps interval", wd_interval, 3);
      do_write(RA, 8'hFF);
      do_read(RA, v);
      check("R12 write leaves flags and bit 6", v, BASE);
      sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
      check("R10 reset clears enable", wd_enable, 0);
      check("R11 reset clears interval", wd_interval, 0);
      do_write(RA, 8'h02);
      check("R10 write ignored during sys_rst", wd_enable, 0);
      step(20);
      do_read(RA, v);
      check("R5 flag after control test", v, BASE | 8'h08);

      finish_run();
   end
endmodule